// File: doc/BRIEF.md
# Atomic Read-Modify-Write Datapath

This block computes the arithmetic part of an atomic read-modify-write access. It has no state. The memory pipeline gives it four things: the register operand, the value just read from memory, an operation code and an access width. In the same cycle the block returns the data to write back, the byte enables for that write, and the value that goes to the destination register. Address generation, translation, ordering and fault handling are done by the pipeline around it.

Before the operation runs, both the register operand and the loaded value are narrowed to the access width and then extended. The unsigned minimum and maximum use zero extension. Every other operation uses sign extension. The destination register always receives the old memory value, sign-extended from the access width. This holds for the unsigned operations too. The write data is placed on a bus as wide as the register, in the byte lane selected by the low address bits. All bytes outside that lane are zero.

The parameter `XLEN` selects a 32-bit or a 64-bit core. Doubleword accesses exist only when `XLEN` is 64.

Top module: `amo_unit`

## Requirements
- R1: Operation code 0 (swap) writes the narrowed register operand unchanged.
- R2: Codes 1 (add), 2 (xor), 3 (and) and 4 (or) write the extended register operand combined with the extended loaded value by that function.
- R3: Codes 5 (signed min) and 6 (signed max) sign-extend both values from the access width and write the smaller or larger of the two, read as two's-complement numbers.
- R4: Codes 7 (unsigned min) and 8 (unsigned max) zero-extend both values from the access width and write the smaller or larger of the two, read as unsigned magnitudes.
- R5: Only the low access-width bytes of the result are written. They are shifted left by `addr_lo_i` bytes, and every other bit of `wdata_o` is zero. The width code is 00 for byte, 01 for halfword, 10 for word and 11 for doubleword.
- R6: For a legal request at an aligned offset, `be_o` holds one bit per written byte. The number of set bits equals the access size in bytes, and the lowest set bit is at position `addr_lo_i`.
- R7: For every operation, `rdata_o` is the loaded value sign-extended from the access width.
- R8: Codes 9 to 15 raise `err_o` and force `be_o` and `wdata_o` to zero.
- R9: When `XLEN` is 32, width code 11 raises `err_o` and forces `be_o` and `wdata_o` to zero. When `XLEN` is 64, width code 11 is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (0..8 legal) |
| width_i | input | 2 | Access width code |
| addr_lo_i | input | log2(XLEN/8) | Byte offset of the access within the bus word |
| rs2_i | input | XLEN | Register operand |
| load_i | input | XLEN | Value read from memory, right-justified |
| wdata_o | output | XLEN | Write data placed in its byte lane |
| be_o | output | XLEN/8 | Byte enables for the write |
| rdata_o | output | XLEN | Value returned to the destination register |
| err_o | output | 1 | Illegal operation code or unsupported width |

## Verification
The assertions are evaluated on every input change. They check the following:
- an error always suppresses the write;
- no set data byte appears outside the enabled lanes;
- the enable count matches the access size for aligned requests;
- the low byte of the return value always follows the loaded byte;
- a min or max result is always one of its two operands;
- zero extension clears the top bit and sign extension replicates the sign bit.

Whether the correct operand was chosen, whether the arithmetic is right, and whether the signed and unsigned ordering differ at each width can only be shown by the bench. It sweeps every operation code, every width and both lane ends over operand pairs that sit on the sign and magnitude boundaries, and it uses a second instance built for a 32-bit core.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_MIN  = 4'd5,
    OP_MAX  = 4'd6,
    OP_MINU = 4'd7,
    OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_DOUBLE = 2'b11
  } amo_size_e;

  function automatic logic op_is_legal(logic [3:0] code);
    return code <= 4'd8;
  endfunction

  function automatic logic op_is_unsigned(logic [3:0] code);
    return (code == OP_MINU) || (code == OP_MAXU);
  endfunction

endpackage

// File: rtl/amo_extend.sv
module amo_extend
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [1:0]      size_i,
  input  logic            zext_i,
  output logic [XLEN-1:0] val_o
);

  logic [XLEN-1:0] ext_b, ext_h, ext_w;

  assign ext_b = zext_i ? {{(XLEN-8){1'b0}}, val_i[7:0]}
                        : {{(XLEN-8){val_i[7]}}, val_i[7:0]};
  assign ext_h = zext_i ? {{(XLEN-16){1'b0}}, val_i[15:0]}
                        : {{(XLEN-16){val_i[15]}}, val_i[15:0]};

  generate
    if (XLEN > 32) begin : g_wide
      assign ext_w = zext_i ? {{(XLEN-32){1'b0}}, val_i[31:0]}
                            : {{(XLEN-32){val_i[31]}}, val_i[31:0]};
    end else begin : g_narrow
      assign ext_w = val_i;
    end
  endgenerate

  always_comb begin
    unique case (amo_size_e'(size_i))
      SZ_BYTE: val_o = ext_b;
      SZ_HALF: val_o = ext_h;
      SZ_WORD: val_o = ext_w;
      default: val_o = val_i;
    endcase
  end

  always_comb begin
    if (zext_i && size_i == SZ_BYTE) begin
      assert_zext_top_clear_R4: assert (val_o[XLEN-1] == 1'b0)
        else $error("zero extension left top bit set");
    end
    if (!zext_i && size_i == SZ_HALF) begin
      assert_sext_top_copy_R3: assert (val_o[XLEN-1] == val_i[15])
        else $error("sign extension lost sign bit");
    end
  end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] opa_i,   // extended register operand
  input  logic [XLEN-1:0] opb_i,   // extended loaded value
  output logic [XLEN-1:0] res_o
);

  logic a_lt_s, a_lt_u;

  assign a_lt_s = $signed(opa_i) < $signed(opb_i);
  assign a_lt_u = opa_i < opb_i;

  always_comb begin
    unique case (amo_op_e'(op_i))
      OP_SWAP: res_o = opa_i;
      OP_ADD:  res_o = opa_i + opb_i;
      OP_XOR:  res_o = opa_i ^ opb_i;
      OP_AND:  res_o = opa_i & opb_i;
      OP_OR:   res_o = opa_i | opb_i;
      OP_MIN:  res_o = a_lt_s ? opa_i : opb_i;
      OP_MAX:  res_o = a_lt_s ? opb_i : opa_i;
      OP_MINU: res_o = a_lt_u ? opa_i : opb_i;
      OP_MAXU: res_o = a_lt_u ? opb_i : opa_i;
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i >= OP_MIN && op_i <= OP_MAXU) begin
      assert_pick_operand_R3: assert (res_o == opa_i || res_o == opb_i)
        else $error("min/max result is neither operand");
    end
  end

endmodule

// File: rtl/amo_lane.sv
module amo_lane
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]             res_i,
  input  logic [1:0]                  size_i,
  input  logic [$clog2(XLEN/8)-1:0]   addr_lo_i,
  input  logic                        kill_i,
  output logic [XLEN-1:0]             wdata_o,
  output logic [XLEN/8-1:0]           be_o
);

  localparam int BE_W  = XLEN / 8;
  localparam int CNT_W = 4;

  logic [CNT_W-1:0] nbytes;
  logic [BE_W-1:0]  base_be;
  logic [XLEN-1:0]  keep;

  assign nbytes = CNT_W'(1) << size_i;

  genvar g;
  generate
    for (g = 0; g < BE_W; g++) begin : g_byte
      assign base_be[g]       = CNT_W'(g) < nbytes;
      assign keep[g*8 +: 8]   = {8{base_be[g]}};
    end
  endgenerate

  assign wdata_o = kill_i ? '0 : (res_i & keep) << {addr_lo_i, 3'b000};
  assign be_o    = kill_i ? '0 : base_be << addr_lo_i;

  generate
    for (g = 0; g < BE_W; g++) begin : g_chk
      always_comb begin
        if (!be_o[g]) begin
          assert_dead_lane_zero_R5: assert (wdata_o[g*8 +: 8] == 8'h00)
            else $error("data in disabled byte lane %0d", g);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]                op_i,
  input  logic [1:0]                width_i,
  input  logic [$clog2(XLEN/8)-1:0] addr_lo_i,
  input  logic [XLEN-1:0]           rs2_i,
  input  logic [XLEN-1:0]           load_i,
  output logic [XLEN-1:0]           wdata_o,
  output logic [XLEN/8-1:0]         be_o,
  output logic [XLEN-1:0]           rdata_o,
  output logic                      err_o
);

  localparam int AW = $clog2(XLEN/8);
  localparam logic HAS_DOUBLE = (XLEN == 64);

  logic            zext;
  logic [XLEN-1:0] opa, opb, res;

  assign zext  = op_is_unsigned(op_i);
  assign err_o = !op_is_legal(op_i) || (width_i == SZ_DOUBLE && !HAS_DOUBLE);

  amo_extend #(.XLEN(XLEN)) u_ext_rs2 (
    .val_i(rs2_i), .size_i(width_i), .zext_i(zext), .val_o(opa));
  amo_extend #(.XLEN(XLEN)) u_ext_ld (
    .val_i(load_i), .size_i(width_i), .zext_i(zext), .val_o(opb));
  // return value is sign-extended regardless of operation
  amo_extend #(.XLEN(XLEN)) u_ext_ret (
    .val_i(load_i), .size_i(width_i), .zext_i(1'b0), .val_o(rdata_o));

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i(op_i), .opa_i(opa), .opb_i(opb), .res_o(res));

  amo_lane #(.XLEN(XLEN)) u_lane (
    .res_i(res), .size_i(width_i), .addr_lo_i(addr_lo_i), .kill_i(err_o),
    .wdata_o(wdata_o), .be_o(be_o));

  logic [3:0]    nb;
  logic [AW-1:0] align_mask;
  assign nb         = 4'd1 << width_i;
  assign align_mask = AW'(nb - 4'd1);

  always_comb begin
    if (err_o) begin
      assert_err_no_write_R8: assert (be_o == '0 && wdata_o == '0)
        else $error("write enabled on illegal request");
    end
    if (!err_o && (addr_lo_i & align_mask) == '0) begin
      assert_be_count_R6: assert ($countones(be_o) == int'(nb))
        else $error("byte enable count mismatch");
    end
    assert_ret_low_byte_R7: assert (rdata_o[7:0] == load_i[7:0])
      else $error("return low byte differs from load");
  end

endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0]  op;
  logic [1:0]  wd;
  logic [2:0]  off;
  logic [63:0] rs2, ld;
  logic [63:0] wdata, rdata;
  logic [7:0]  be;
  logic        err;

  amo_unit #(.XLEN(64)) dut_i (
    .op_i(op), .width_i(wd), .addr_lo_i(off), .rs2_i(rs2), .load_i(ld),
    .wdata_o(wdata), .be_o(be), .rdata_o(rdata), .err_o(err));

  logic [3:0]  s_op;
  logic [1:0]  s_wd;
  logic [1:0]  s_off;
  logic [31:0] s_rs2, s_ld, s_wdata, s_rdata;
  logic [3:0]  s_be;
  logic        s_err;

  amo_unit #(.XLEN(32)) dut32_i (
    .op_i(s_op), .width_i(s_wd), .addr_lo_i(s_off), .rs2_i(s_rs2), .load_i(s_ld),
    .wdata_o(s_wdata), .be_o(s_be), .rdata_o(s_rdata), .err_o(s_err));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(logic [63:0] v, int nbytes);
    int sh = 64 - 8 * nbytes;
    return 64'($signed(v << sh) >>> sh);
  endfunction

  function automatic logic [63:0] zx(logic [63:0] v, int nbytes);
    int sh = 64 - 8 * nbytes;
    return (v << sh) >> sh;
  endfunction

  function automatic string op_tag(int o);
    if (o == 0) return "R1";
    if (o <= 4) return "R2";
    if (o <= 6) return "R3";
    if (o <= 8) return "R4";
    return "R8";
  endfunction

  task automatic run(input int o, input int w, input int ofs,
                     input logic [63:0] a_in, input logic [63:0] b_in);
    int nbytes = 1 << w;
    bit legal = (o <= 8);
    bit uns = (o == 7) || (o == 8);
    logic [63:0] a, b, r, mask, ew, er;
    logic [7:0] eb;
    @(posedge clk);
    op = 4'(o); wd = 2'(w); off = 3'(ofs); rs2 = a_in; ld = b_in;
    @(negedge clk);
    a = uns ? zx(a_in, nbytes) : sx(a_in, nbytes);
    b = uns ? zx(b_in, nbytes) : sx(b_in, nbytes);
    case (o)
      0: r = a;
      1: r = a + b;
      2: r = a ^ b;
      3: r = a & b;
      4: r = a | b;
      5: r = ($signed(a) < $signed(b)) ? a : b;
      6: r = ($signed(a) > $signed(b)) ? a : b;
      7: r = (a < b) ? a : b;
      8: r = (a > b) ? a : b;
      default: r = '0;
    endcase
    mask = (nbytes == 8) ? '1 : ((64'd1 << (8 * nbytes)) - 64'd1);
    ew = legal ? ((r & mask) << (8 * ofs)) : 64'd0;
    eb = legal ? 8'(((1 << nbytes) - 1) << ofs) : 8'd0;
    er = sx(b_in, nbytes);
    check(wdata === ew, legal ? {op_tag(o), "/R5 wdata"} : "R8 wdata", wdata, ew);
    check(be === eb, legal ? "R6 be" : "R8 be", 64'(be), 64'(eb));
    check(rdata === er, "R7 rdata", rdata, er);
    check(err === !legal, "R8 err", 64'(err), 64'(!legal));
  endtask

  task automatic run32(input int o, input int w, input logic [31:0] a_in,
                       input logic [31:0] b_in, input logic [31:0] ew,
                       input logic [3:0] eb, input logic [31:0] er, input logic ee);
    @(posedge clk);
    s_op = 4'(o); s_wd = 2'(w); s_off = 2'd0; s_rs2 = a_in; s_ld = b_in;
    @(negedge clk);
    check(s_wdata === ew, "R9 wdata32", 64'(s_wdata), 64'(ew));
    check(s_be === eb, "R9 be32", 64'(s_be), 64'(eb));
    check(s_rdata === er, "R7 rdata32", 64'(s_rdata), 64'(er));
    check(s_err === ee, "R9 err32", 64'(s_err), 64'(ee));
  endtask

  logic [63:0] pats [10];

  initial begin
    pats[0] = 64'h0000_0000_0000_0000;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[4] = 64'h0000_0000_0000_0080;
    pats[5] = 64'h0000_0000_0000_007F;
    pats[6] = 64'h0000_0000_8000_8001;
    pats[7] = 64'h1234_5678_9ABC_DEF0;
    pats[8] = 64'hFEDC_BA98_7654_3210;
    pats[9] = 64'h0000_0000_7FFF_FF80;
    op = '0; wd = '0; off = '0; rs2 = '0; ld = '0;
    s_op = '0; s_wd = '0; s_off = '0; s_rs2 = '0; s_ld = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle inputs: byte swap of zero at offset 0
    check(wdata === 64'd0, "R1 idle wdata", wdata, 64'd0);
    check(be === 8'h01, "R6 idle be", 64'(be), 64'h01);
    check(err === 1'b0, "R8 idle err", 64'(err), 64'd0);

    for (int o = 0; o < 16; o++)
      for (int w = 0; w < 4; w++)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++) begin
            run(o, w, 0, pats[i], pats[j]);
            run(o, w, 8 - (1 << w), pats[j], pats[i]);
          end

    // 32-bit configuration
    run32(1, 2, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 4'hF, 32'h0000_0001, 1'b0);
    run32(7, 0, 32'h0000_0080, 32'h0000_0001, 32'h0000_0001, 4'h1, 32'h0000_0001, 1'b0);
    run32(5, 0, 32'h0000_0080, 32'h0000_0001, 32'h0000_0080, 4'h1, 32'h0000_0001, 1'b0);
    run32(0, 2, 32'hCAFE_F00D, 32'h8000_0000, 32'hCAFE_F00D, 4'hF, 32'h8000_0000, 1'b0);
    run32(0, 3, 32'hCAFE_F00D, 32'h1234_5678, 32'h0000_0000, 4'h0, 32'h1234_5678, 1'b1);
    run32(9, 1, 32'h0000_1111, 32'h0000_8000, 32'h0000_0000, 4'h0, 32'hFFFF_8000, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule